// File: doc/BRIEF.md
# Dirty Page Bitmap Tracker

This block sits beside a device's outbound write path and records which host memory pages the device has modified. Each tracked write arrives as a start address and a length. The block converts the covered address range into page numbers and then into bitmap byte positions. For every byte position that needs a mark it issues a one-byte memory write into a bitmap held in host memory. Software later scans that bitmap during live migration.

Each bitmap bit stands for one page. Bit n belongs to page n, and page n covers addresses from n shifted left by the page exponent. The block never reads the bitmap. Instead it writes the whole byte that holds a page's bit as 0xFF, which also marks the seven neighbouring pages. Software programs the enable, bitmap base, bitmap size in bytes, page exponent and PASID through a strobed control port. Marks at or beyond the programmed size are clipped. A one-entry history of the last byte written drops back-to-back repeats of the same byte.

Top module: `dirty_page_tracker`

## Requirements
- R1: After synchronous reset, `mark_valid` is 0, `trk_ready` is 1, tracking is disabled and the stored PASID is 0; tracked writes accepted in this state produce no bitmap write.
- R2: A tracked write at address A with stored page exponent E produces a bitmap write with `mark_addr` = base + (A >> (E+3)) and `mark_data` = 0xFF.
- R3: While the stored enable is 0, tracked writes are still accepted, but no bitmap write is issued.
- R4: A byte position at or above the stored bitmap length in bytes is never written. Marks that would fall there are dropped.
- R5: A tracked write covering addresses A to A+`trk_len_m1` produces one bitmap write for each distinct byte position from the first to the last, in ascending order.
- R6: The PASID value is stored only when both `pasid_cap_present` and `pasid_enabled` are 1 during a control write. Otherwise it keeps its old value. `mark_pasid` carries the stored value at the time of each bitmap write.
- R7: While `mark_valid` is 1 and `mark_ready` is 0, `mark_valid`, `mark_addr`, `mark_data` and `mark_pasid` hold steady. `trk_ready` is 0 whenever a tracked write is being expanded or a bitmap write is pending.
- R8: A byte position equal to the most recently written one is skipped. This history is cleared by a control write that disables tracking or that changes the bitmap base.
- R9: A programmed page exponent below 12 is stored as 12, and one above 30 is stored as 30.
- R10: Control fields change only in a cycle where `cfg_we` is 1. Changes on the control inputs at other times have no effect on the bitmap writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Tracking enable value |
| cfg_bitmap_addr | input | AW | Bitmap base address value |
| cfg_bitmap_len | input | LW | Bitmap size in bytes value |
| cfg_page_exp | input | 5 | Page size exponent value |
| cfg_pasid | input | PW | PASID value |
| pasid_cap_present | input | 1 | PASID capability is implemented |
| pasid_enabled | input | 1 | PASID use is switched on |
| trk_valid | input | 1 | Tracked write presented |
| trk_ready | output | 1 | Tracked write accepted this cycle if valid |
| trk_addr | input | AW | Tracked write start address |
| trk_len_m1 | input | LENW | Tracked write length in bytes minus one |
| mark_valid | output | 1 | Bitmap byte write request |
| mark_ready | input | 1 | Memory side accepts the request |
| mark_addr | output | AW | Bitmap byte address |
| mark_data | output | 8 | Byte value written (0xFF) |
| mark_pasid | output | PW | PASID attached to the request |

## Verification
Properties are checked on every cycle for four things. A pending request must hold steady under back-pressure, and its data must be all ones. A request may only start while tracking is enabled and only for a byte position inside the bitmap. Two successive issues may not hit the same byte unless the history was cleared. The stored exponent must stay in range, the stored PASID must hold when PASID is unavailable, and control state must not move without the strobe. The bench scenarios are needed to show that the address arithmetic is right, that spans expand in order across several bytes, and that history clearing re-enables a mark. They also show that ignored control inputs really leave the output addresses and PASID unchanged.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int EXP_W = 5;

  typedef enum logic {
    W_IDLE = 1'b0,
    W_WALK = 1'b1
  } walk_state_e;

  // Width of a bitmap byte index able to hold (2^(aw+1)-1) >> (min_exp+3)
  function automatic int idx_width(input int aw, input int min_exp);
    return aw + 1 - min_exp - 3;
  endfunction

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] v,
                                                 input int lo, input int hi);
    if (int'(v) < lo) return EXP_W'(lo);
    if (int'(v) > hi) return EXP_W'(hi);
    return v;
  endfunction

endpackage

// File: rtl/dpt_ctrl_regs.sv
module dpt_ctrl_regs #(
  parameter int AW      = 48,
  parameter int LW      = 32,
  parameter int PW      = 20,
  parameter int MIN_EXP = 12,
  parameter int MAX_EXP = 30
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_enable,
  input  logic [AW-1:0]             cfg_bitmap_addr,
  input  logic [LW-1:0]             cfg_bitmap_len,
  input  logic [dpt_pkg::EXP_W-1:0] cfg_page_exp,
  input  logic [PW-1:0]             cfg_pasid,
  input  logic                      pasid_cap_present,
  input  logic                      pasid_enabled,
  output logic                      enable_q,
  output logic [AW-1:0]             base_q,
  output logic [LW-1:0]             len_q,
  output logic [dpt_pkg::EXP_W-1:0] exp_q,
  output logic [PW-1:0]             pasid_q,
  output logic                      hist_clear
);
  import dpt_pkg::*;

  logic pasid_wr_ok;
  assign pasid_wr_ok = pasid_cap_present && pasid_enabled;

  // History is stale when tracking stops or the bitmap moves
  assign hist_clear = cfg_we && (!cfg_enable || (cfg_bitmap_addr != base_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      exp_q    <= EXP_W'(MIN_EXP);
      pasid_q  <= '0;
    end else if (cfg_we) begin
      enable_q <= cfg_enable;
      base_q   <= cfg_bitmap_addr;
      len_q    <= cfg_bitmap_len;
      exp_q    <= clamp_exp(cfg_page_exp, MIN_EXP, MAX_EXP);
      if (pasid_wr_ok) pasid_q <= cfg_pasid;
    end
  end

  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(exp_q) >= MIN_EXP) && (int'(exp_q) <= MAX_EXP)); // R9

  AST_PASID_KEEP: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !pasid_wr_ok) |=> $stable(pasid_q)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(enable_q) && $stable(base_q) && $stable(len_q) && $stable(exp_q))); // R10

endmodule

// File: rtl/dpt_range_walker.sv
module dpt_range_walker #(
  parameter int AW      = 48,
  parameter int LW      = 32,
  parameter int LENW    = 16,
  parameter int MIN_EXP = 12,
  localparam int IW     = dpt_pkg::idx_width(AW, MIN_EXP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic [LW-1:0]             bitmap_len,
  input  logic [dpt_pkg::EXP_W-1:0] page_exp,
  input  logic                      hist_clear,
  input  logic                      trk_valid,
  output logic                      trk_ready,
  input  logic [AW-1:0]             trk_addr,
  input  logic [LENW-1:0]           trk_len_m1,
  input  logic                      req_busy,
  input  logic                      req_ready,
  output logic                      issue,
  output logic [IW-1:0]             issue_idx
);
  import dpt_pkg::*;

  walk_state_e state_q;
  logic [IW-1:0] cur_q, end_q, hist_idx_q;
  logic          hist_v_q;

  // Start and last byte index of the incoming range
  logic [5:0]  shamt;
  logic [AW:0] last_addr, start_full, end_full;
  logic [IW-1:0] start_idx, end_idx;
  logic unused_hi;

  assign shamt      = {1'b0, page_exp} + 6'd3;
  assign last_addr  = {1'b0, trk_addr} + {{(AW+1-LENW){1'b0}}, trk_len_m1};
  assign start_full = {1'b0, trk_addr} >> shamt;
  assign end_full   = last_addr >> shamt;
  assign start_idx  = start_full[IW-1:0];
  assign end_idx    = end_full[IW-1:0];
  assign unused_hi  = ^{start_full[AW:IW], end_full[AW:IW]};

  logic idle, accept, past_end, out_bound, dup, walk_done, can_issue;

  assign idle      = (state_q == W_IDLE);
  assign trk_ready = idle && !req_busy;
  assign accept    = trk_valid && trk_ready;
  assign past_end  = cur_q > end_q;
  assign out_bound = {{LW{1'b0}}, cur_q} >= {{IW{1'b0}}, bitmap_len};
  assign dup       = hist_v_q && (hist_idx_q == cur_q);
  assign walk_done = !enable || past_end || out_bound;
  assign can_issue = !req_busy || req_ready;
  assign issue     = !idle && !walk_done && !dup && can_issue;
  assign issue_idx = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= W_IDLE;
      cur_q      <= '0;
      end_q      <= '0;
      hist_v_q   <= 1'b0;
      hist_idx_q <= '0;
    end else begin
      case (state_q)
        W_IDLE: begin
          if (accept && enable) begin
            state_q <= W_WALK;
            cur_q   <= start_idx;
            end_q   <= end_idx;
          end
        end
        W_WALK: begin
          if (walk_done)          state_q <= W_IDLE;
          else if (dup || issue)  cur_q   <= cur_q + 1'b1;
        end
        default: state_q <= W_IDLE;
      endcase
      if (issue) begin
        hist_v_q   <= 1'b1;
        hist_idx_q <= cur_q;
      end
      if (hist_clear) hist_v_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dpt_mark_req.sv
module dpt_mark_req #(
  parameter int AW      = 48,
  parameter int PW      = 20,
  parameter int MIN_EXP = 12,
  localparam int IW     = dpt_pkg::idx_width(AW, MIN_EXP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [IW-1:0] issue_idx,
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pasid,
  output logic          mark_valid,
  input  logic          mark_ready,
  output logic [AW-1:0] mark_addr,
  output logic [7:0]    mark_data,
  output logic [PW-1:0] mark_pasid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_valid <= 1'b0;
      mark_addr  <= '0;
      mark_data  <= 8'h00;
      mark_pasid <= '0;
    end else if (issue) begin
      mark_valid <= 1'b1;
      mark_addr  <= base + {{(AW-IW){1'b0}}, issue_idx};
      mark_data  <= 8'hFF;
      mark_pasid <= pasid;
    end else if (mark_ready) begin
      mark_valid <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mark_valid && !mark_ready) |=> (mark_valid && $stable(mark_addr) &&
                                     $stable(mark_data) && $stable(mark_pasid))); // R7

  AST_DATA_ONES: assert property (@(posedge clk) disable iff (rst)
    mark_valid |-> (mark_data == 8'hFF)); // R2

endmodule

// File: rtl/dirty_page_tracker.sv
module dirty_page_tracker #(
  parameter int AW      = 48,
  parameter int LW      = 32,
  parameter int PW      = 20,
  parameter int LENW    = 16,
  parameter int MIN_EXP = 12,
  parameter int MAX_EXP = 30
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_enable,
  input  logic [AW-1:0]             cfg_bitmap_addr,
  input  logic [LW-1:0]             cfg_bitmap_len,
  input  logic [dpt_pkg::EXP_W-1:0] cfg_page_exp,
  input  logic [PW-1:0]             cfg_pasid,
  input  logic                      pasid_cap_present,
  input  logic                      pasid_enabled,
  input  logic                      trk_valid,
  output logic                      trk_ready,
  input  logic [AW-1:0]             trk_addr,
  input  logic [LENW-1:0]           trk_len_m1,
  output logic                      mark_valid,
  input  logic                      mark_ready,
  output logic [AW-1:0]             mark_addr,
  output logic [7:0]                mark_data,
  output logic [PW-1:0]             mark_pasid
);
  import dpt_pkg::*;

  localparam int IW = idx_width(AW, MIN_EXP);

  logic              enable_q, hist_clear, issue;
  logic [AW-1:0]     base_q;
  logic [LW-1:0]     len_q;
  logic [EXP_W-1:0]  exp_q;
  logic [PW-1:0]     pasid_q;
  logic [IW-1:0]     issue_idx;

  dpt_ctrl_regs #(.AW(AW), .LW(LW), .PW(PW), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP)) ctrl_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_bitmap_addr(cfg_bitmap_addr), .cfg_bitmap_len(cfg_bitmap_len),
    .cfg_page_exp(cfg_page_exp), .cfg_pasid(cfg_pasid),
    .pasid_cap_present(pasid_cap_present), .pasid_enabled(pasid_enabled),
    .enable_q(enable_q), .base_q(base_q), .len_q(len_q), .exp_q(exp_q),
    .pasid_q(pasid_q), .hist_clear(hist_clear)
  );

  dpt_range_walker #(.AW(AW), .LW(LW), .LENW(LENW), .MIN_EXP(MIN_EXP)) walk_i (
    .clk(clk), .rst(rst), .enable(enable_q), .bitmap_len(len_q), .page_exp(exp_q),
    .hist_clear(hist_clear), .trk_valid(trk_valid), .trk_ready(trk_ready),
    .trk_addr(trk_addr), .trk_len_m1(trk_len_m1), .req_busy(mark_valid),
    .req_ready(mark_ready), .issue(issue), .issue_idx(issue_idx)
  );

  dpt_mark_req #(.AW(AW), .PW(PW), .MIN_EXP(MIN_EXP)) req_i (
    .clk(clk), .rst(rst), .issue(issue), .issue_idx(issue_idx), .base(base_q),
    .pasid(pasid_q), .mark_valid(mark_valid), .mark_ready(mark_ready),
    .mark_addr(mark_addr), .mark_data(mark_data), .mark_pasid(mark_pasid)
  );

  AST_NO_MARK_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(mark_valid) |-> $past(enable_q)); // R3

  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    issue |-> ({{LW{1'b0}}, issue_idx} < {{IW{1'b0}}, len_q})); // R4

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (issue && $past(issue) && !$past(hist_clear)) |-> (issue_idx != $past(issue_idx))); // R8

endmodule

// File: tb/dirty_page_tracker_tb_top.sv
`timescale 1ns/1ps
module dirty_page_tracker_tb_top;
  localparam int AW = 48, LW = 32, PW = 20, LENW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_we = 0, cfg_enable = 0, pasid_cap_present = 0, pasid_enabled = 0;
  logic [AW-1:0] cfg_bitmap_addr = '0;
  logic [LW-1:0] cfg_bitmap_len = '0;
  logic [4:0] cfg_page_exp = 5'd12;
  logic [PW-1:0] cfg_pasid = '0;
  logic trk_valid = 0, trk_ready;
  logic [AW-1:0] trk_addr = '0;
  logic [LENW-1:0] trk_len_m1 = '0;
  logic mark_valid, mark_ready = 1'b1;
  logic [AW-1:0] mark_addr;
  logic [7:0] mark_data;
  logic [PW-1:0] mark_pasid;

  dirty_page_tracker dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_bitmap_addr(cfg_bitmap_addr), .cfg_bitmap_len(cfg_bitmap_len),
    .cfg_page_exp(cfg_page_exp), .cfg_pasid(cfg_pasid),
    .pasid_cap_present(pasid_cap_present), .pasid_enabled(pasid_enabled),
    .trk_valid(trk_valid), .trk_ready(trk_ready), .trk_addr(trk_addr),
    .trk_len_m1(trk_len_m1), .mark_valid(mark_valid), .mark_ready(mark_ready),
    .mark_addr(mark_addr), .mark_data(mark_data), .mark_pasid(mark_pasid)
  );

  int checks = 0, errors = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [PW-1:0] pasid;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // Reference state kept from the requirements
  logic m_en = 0, m_hv = 0;
  longint unsigned m_base = 0, m_len = 0, m_exp = 12, m_hidx = 0;
  logic [PW-1:0] m_pasid = '0;

  // Back-pressure generator
  logic stall = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    mark_ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  // Monitor / scoreboard
  logic hold_pend = 0;
  logic [AW-1:0] hold_addr;
  int hold_n = 0, rdy_n = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend && hold_n < 6) begin
        hold_n++; checks++;
        if (!(mark_valid && mark_addr == hold_addr)) begin
          errors++;
          $display("FAIL R7 hold: valid=%0b addr=%h expected valid=1 addr=%h", mark_valid, mark_addr, hold_addr);
        end
      end
      hold_pend = mark_valid && !mark_ready;
      hold_addr = mark_addr;
      if (mark_valid && rdy_n < 4) begin
        rdy_n++; checks++;
        if (trk_ready !== 1'b0) begin
          errors++;
          $display("FAIL R7 trk_ready=%0b expected 0 while request pending", trk_ready);
        end
      end
      if (mark_valid && mark_ready) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected write addr=%h expected none", mark_addr);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (mark_addr !== e.addr || mark_data !== 8'hFF || mark_pasid !== e.pasid) begin
            errors++;
            $display("FAIL %s addr=%h data=%h pasid=%h expected addr=%h data=ff pasid=%h",
                     e.tag, mark_addr, mark_data, mark_pasid, e.addr, e.pasid);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!(trk_ready && !mark_valid));
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_drained(input string tag);
    wait_idle();
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing writes=%0d expected 0", tag, sb_q.size());
      sb_q.delete();
    end
  endtask

  task automatic cfg(input logic en, input longint unsigned base, input longint unsigned len,
                     input int ex, input int pasid, input logic cap, input logic pen);
    if (!en || base != m_base) m_hv = 0;
    m_en = en; m_base = base; m_len = len;
    m_exp = (ex < 12) ? 12 : (ex > 30) ? 30 : ex;
    if (cap && pen) m_pasid = PW'(pasid);
    @(posedge clk); #1;
    cfg_we = 1; cfg_enable = en; cfg_bitmap_addr = AW'(base); cfg_bitmap_len = LW'(len);
    cfg_page_exp = 5'(ex); cfg_pasid = PW'(pasid); pasid_cap_present = cap; pasid_enabled = pen;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic track(input longint unsigned addr, input longint unsigned lm1, input string tag);
    if (m_en) begin
      longint unsigned s, e;
      s = addr >> (m_exp + 3);
      e = (addr + lm1) >> (m_exp + 3);
      for (longint unsigned i = s; i <= e; i++) begin
        exp_t it;
        if (i >= m_len) break;
        if (m_hv && i == m_hidx) continue;
        it.addr = AW'(m_base + i); it.pasid = m_pasid; it.tag = tag;
        sb_q.push_back(it);
        m_hv = 1; m_hidx = i;
      end
    end
    @(posedge clk); #1;
    trk_valid = 1; trk_addr = AW'(addr); trk_len_m1 = LENW'(lm1);
    begin
      logic r;
      do begin
        @(negedge clk); r = trk_ready;
        @(posedge clk);
      end while (!r);
    end
    #1 trk_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    checks++;
    if (mark_valid !== 1'b0 || trk_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset mark_valid=%0b trk_ready=%0b expected 0 1", mark_valid, trk_ready);
    end
    track(48'h5000, 0, "R1");
    expect_drained("R1");

    cfg(1, 64'h1000_0000, 16, 12, 5, 1, 1);
    track(48'h0, 0, "R2");
    track(48'h0, 0, "R8 repeat");
    track(48'h9000, 0, "R2");
    track(48'h3000, 0, "R8 alternate");
    expect_drained("R8");

    track(48'h7000, 16'h2000, "R5");
    stall = 1;
    track(48'h0, 16'hFFFF, "R5 stall");
    track(48'h10000, 16'hFFFF, "R7 stall");
    expect_drained("R5");
    stall = 0;

    track(48'h7F000, 0, "R4 last byte");
    track(48'h80000, 0, "R4 past end");
    track(48'h7E000, 16'h3FFF, "R4 straddle");
    track(48'h100000, 0, "R4 far");
    expect_drained("R4");

    cfg(0, 64'h1000_0000, 16, 12, 5, 1, 1);
    track(48'h1000, 0, "R3");
    expect_drained("R3");
    cfg(1, 64'h1000_0000, 16, 12, 5, 1, 1);
    track(48'h7F000, 0, "R8 cleared by disable");
    cfg(1, 64'h2000_0000, 16, 12, 5, 1, 1);
    track(48'h7F000, 0, "R8 cleared by base");
    expect_drained("R8");

    cfg(1, 64'h2000_0000, 16, 12, 7, 1, 0);
    track(48'h8000, 0, "R6 pasid disabled");
    cfg(1, 64'h2000_0000, 16, 12, 9, 0, 1);
    track(48'h10000, 0, "R6 no capability");
    cfg(1, 64'h2000_0000, 16, 12, 10, 1, 1);
    track(48'h18000, 0, "R6 pasid stored");
    expect_drained("R6");

    cfg(1, 64'h3000_0000, 64'h1000, 5, 10, 1, 1);
    track(48'h9000, 0, "R9 low clamp");
    cfg(1, 64'h3000_0000, 64'h1000, 31, 10, 1, 1);
    track(48'h2_0000_0000, 0, "R9 high clamp");
    track(48'h10_0000_0000, 0, "R9 high clamp");
    expect_drained("R9");

    @(posedge clk); #1;
    cfg_bitmap_addr = 48'h4000_0000; cfg_enable = 0; cfg_page_exp = 5'd12;
    track(48'h40_0000_0000, 0, "R10");
    expect_drained("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule